// File: doc/BRIEF.md
# Parity-Selectable Serial Byte Transmitter

This block turns one byte from a host into an asynchronous serial character on a single line. The host puts the byte on the 8-bit data bus and pulls the active-low write strobe low. The block captures the byte and the parity sense on that strobe. It then sends a low start bit, the eight data bits least significant bit first, a parity bit and a high stop bit. A character is 11 line bits long. The block only reads the shared data bus and never drives it, so the bus enters as an input.

All timing comes from one master clock that runs at sixteen times the line bit rate. Every line bit therefore lasts sixteen master-clock cycles. The block shows that a character is in flight on `busy` and that it can take a new byte on `txReady`. A strobe that arrives while a character is going out is ignored.

Top module: `uart_tx`

## Requirements
- R1: While reset is high, and after it is released with no write, `txLine` is 1, `busy` is 0 and `txReady` is 1.
- R2: A write is taken at the first rising clock edge where `wrN` is sampled 0 after it was sampled 1 at the edge before, with the block idle. After that edge `busy` is 1 and `txLine` is 0 (the start bit).
- R3: The frame on `txLine` is one start bit of 0, then `wrData` bit 0 through bit 7 in that order, then the parity bit, then one stop bit of 1.
- R4: Each of the 11 line bits holds its value for exactly 16 clock cycles.
- R5: When `paritySel` is 0 at the write, the parity bit is the XOR of the eight data bits (even parity).
- R6: When `paritySel` is 1 at the write, the parity bit is the inverted XOR of the eight data bits (odd parity).
- R7: `busy` stays 1 for exactly 176 cycles after the write edge and then returns to 0 with `txLine` at 1. A new write can be taken at the very next edge.
- R8: A falling strobe while `busy` is 1 is ignored and does not alter the character in flight. A strobe held low from a busy period into idle does not count as a new write.
- R9: `txReady` is always the complement of `busy`.
- R10: Changes on `wrData` or `paritySel` after the write edge have no effect on the character being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk16x | input | 1 | Master clock at sixteen times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| wrN | input | 1 | Active-low write strobe |
| wrData | input | 8 | Byte on the shared host data bus |
| paritySel | input | 1 | Parity sense: 0 gives even, 1 gives odd |
| txLine | output | 1 | Serial line output, high when idle |
| busy | output | 1 | High while a character is being sent |
| txReady | output | 1 | High when a new byte can be written |

## Verification
The hardest cases to reach are a strobe edge that lands in the middle of a character, and a strobe held low across the end of a character. Either one could start a spurious second frame or corrupt the shift register. The bench drives extra falling strobes with different bus data at chosen cycles inside a frame. It also holds the strobe low from mid-frame until well after the stop bit. Meanwhile it decodes the line at mid-bit and compares every cycle against a queue-based model of the line.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  // Strobes sent from the control to the datapath
  typedef struct packed {
    logic load;   // capture byte and parity into the frame register
    logic shift;  // advance to the next line bit
  } txCtrl_t;
endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int FRAME_BITS = 11
) (
  input  logic    clk16x,
  input  logic    rst,
  input  logic    wrN,
  output txCtrl_t ctrl,
  output logic    busy,
  output logic    txReady
);
  localparam int CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam int BIT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] TICK_LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0] BIT_LAST  = BIT_W'(FRAME_BITS - 1);

  logic             busyQ;
  logic             readyQ;
  logic             wrNPrevQ;
  logic [CNT_W-1:0] tickQ;
  logic [BIT_W-1:0] bitQ;
  logic             writeReq;
  logic             bitEnd;

  // a falling strobe edge, seen only while idle
  assign writeReq = !wrN && wrNPrevQ && !busyQ;
  assign bitEnd   = busyQ && (tickQ == TICK_LAST);

  always_comb begin
    ctrl       = '0;
    ctrl.load  = writeReq;
    ctrl.shift = bitEnd && (bitQ != BIT_LAST);
  end

  always_ff @(posedge clk16x) begin
    if (rst) begin
      busyQ    <= 1'b0;
      readyQ   <= 1'b1;
      wrNPrevQ <= 1'b1;
      tickQ    <= '0;
      bitQ     <= '0;
    end else begin
      wrNPrevQ <= wrN;
      if (writeReq) begin
        busyQ  <= 1'b1;
        readyQ <= 1'b0;
        tickQ  <= '0;
        bitQ   <= '0;
      end else if (busyQ) begin
        if (bitEnd) begin
          tickQ <= '0;
          if (bitQ == BIT_LAST) begin
            busyQ  <= 1'b0;
            readyQ <= 1'b1;
          end else begin
            bitQ <= bitQ + 1'b1;
          end
        end else begin
          tickQ <= tickQ + 1'b1;
        end
      end
    end
  end

  assign busy    = busyQ;
  assign txReady = readyQ;
endmodule

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath
  import uart_tx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk16x,
  input  logic                 rst,
  input  txCtrl_t              ctrl,
  input  logic [DATA_BITS-1:0] wrData,
  input  logic                 paritySel,
  output logic                 txLine
);
  localparam int FRAME_BITS = DATA_BITS + 3;

  logic [FRAME_BITS-1:0] frameQ;
  logic                  parityBit;

  // even: plain XOR; odd: inverted XOR
  assign parityBit = (^wrData) ^ paritySel;

  always_ff @(posedge clk16x) begin
    if (rst) begin
      frameQ <= '1;
    end else if (ctrl.load) begin
      frameQ <= {1'b1, parityBit, wrData, 1'b0};
    end else if (ctrl.shift) begin
      frameQ <= {1'b1, frameQ[FRAME_BITS-1:1]};
    end
  end

  assign txLine = frameQ[0];
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk16x,
  input  logic                 rst,
  input  logic                 wrN,
  input  logic [DATA_BITS-1:0] wrData,
  input  logic                 paritySel,
  output logic                 txLine,
  output logic                 busy,
  output logic                 txReady
);
  import uart_tx_pkg::*;
  localparam int FRAME_BITS = DATA_BITS + 3;

  txCtrl_t ctrl;

  uart_tx_ctrl #(
    .OVERSAMPLE(OVERSAMPLE),
    .FRAME_BITS(FRAME_BITS)
  ) u_ctrl (
    .clk16x (clk16x),
    .rst    (rst),
    .wrN    (wrN),
    .ctrl   (ctrl),
    .busy   (busy),
    .txReady(txReady)
  );

  uart_tx_datapath #(
    .DATA_BITS(DATA_BITS)
  ) u_dp (
    .clk16x   (clk16x),
    .rst      (rst),
    .ctrl     (ctrl),
    .wrData   (wrData),
    .paritySel(paritySel),
    .txLine   (txLine)
  );
endmodule

// File: rtl/uart_tx_checker.sv
module uart_tx_checker #(
  parameter int OVERSAMPLE = 16
) (
  input logic clk16x,
  input logic rst,
  input logic wrN,
  input logic txLine,
  input logic busy,
  input logic txReady
);
  localparam int PH_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  logic [PH_W-1:0] phaseQ;

  // cycles since the frame started, modulo one bit time
  always_ff @(posedge clk16x) begin
    if (rst || !busy) phaseQ <= '0;
    else if (phaseQ == PH_W'(OVERSAMPLE - 1)) phaseQ <= '0;
    else phaseQ <= phaseQ + 1'b1;
  end

  assert_idle_high_R1: assert property (@(posedge clk16x) disable iff (rst)
    !busy |-> txLine);

  assert_start_low_R2: assert property (@(posedge clk16x) disable iff (rst)
    $rose(busy) |-> (!txLine && $past(!wrN)));

  assert_bit_width_R4: assert property (@(posedge clk16x) disable iff (rst)
    (busy && $past(busy) && (txLine != $past(txLine))) |-> (phaseQ == '0));

  assert_stop_high_R7: assert property (@(posedge clk16x) disable iff (rst)
    $fell(busy) |-> txLine);

  assert_ready_flag_R9: assert property (@(posedge clk16x) disable iff (rst)
    txReady == !busy);
endmodule

bind uart_tx uart_tx_checker #(.OVERSAMPLE(OVERSAMPLE)) u_chk (
  .clk16x (clk16x),
  .rst    (rst),
  .wrN    (wrN),
  .txLine (txLine),
  .busy   (busy),
  .txReady(txReady)
);

// File: tb/uart_tx_tb.sv
`timescale 1ns/1ps
module uart_tx_tb;
  logic       clk16x = 1'b0;
  logic       rst = 1'b1;
  logic       wrN = 1'b1;
  logic [7:0] wrData = 8'h00;
  logic       paritySel = 1'b0;
  logic       txLine, busy, txReady;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk16x = ~clk16x;

  uart_tx u_dut (
    .clk16x(clk16x), .rst(rst), .wrN(wrN), .wrData(wrData),
    .paritySel(paritySel), .txLine(txLine), .busy(busy), .txReady(txReady)
  );

  // reference model: queue of expected line values, one per cycle
  bit lineQ[$];
  bit refBusy = 1'b0;
  bit refPrevWr = 1'b1;

  always @(posedge clk16x) begin
    if (rst) begin
      lineQ.delete();
      refBusy = 1'b0;
      refPrevWr = 1'b1;
    end else begin
      if (!refBusy && !wrN && refPrevWr) begin
        bit fr[11];
        fr[0] = 1'b0;
        for (int i = 0; i < 8; i++) fr[i+1] = wrData[i];
        fr[9] = paritySel ? ~(^wrData) : (^wrData);
        fr[10] = 1'b1;
        for (int b = 0; b < 11; b++)
          for (int t = 0; t < 16; t++) lineQ.push_back(fr[b]);
        refBusy = 1'b1;
      end else if (refBusy) begin
        void'(lineQ.pop_front());
        if (lineQ.size() == 0) refBusy = 1'b0;
      end
      refPrevWr = wrN;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk16x) begin
    if (!rst && !done) begin
      bit expLine;
      expLine = refBusy ? lineQ[0] : 1'b1;
      check(txLine == expLine, "R3 line", txLine, expLine);
      check(busy == refBusy, "R7 busy", busy, refBusy);
      check(txReady == !refBusy, "R9 ready", txReady, !refBusy);
    end
  end

  // send one byte, decode the line at mid-bit
  task automatic sendFrame(input logic [7:0] d, input bit par,
                           input int injectAt, input bit holdLow);
    bit got[11];
    bit expPar;
    expPar = par ? ~(^d) : (^d);
    wrData = d;
    paritySel = par;
    wrN = 1'b0;
    @(negedge clk16x);  // after the accepting edge
    wrN = 1'b1;
    check(busy == 1'b1 && txLine == 1'b0, "R2 accept", {busy, txLine}, 2'b10);
    wrData = ~d;        // R10: bus changes after capture
    paritySel = ~par;
    for (int c = 0; c < 176; c++) begin
      if (c % 16 == 8) got[c/16] = txLine;
      if (c == injectAt) begin wrN = 1'b0; wrData = 8'h5A; end
      if (c == injectAt + 3 && !holdLow) wrN = 1'b1;
      if (c % 16 == 15) begin
        // last cycle of a bit must still show the mid-bit value (R4)
        check(txLine == got[c/16], "R4 bit hold", txLine, got[c/16]);
      end
      @(negedge clk16x);
    end
    check(got[0] == 1'b0, "R3 start", got[0], 0);
    for (int i = 0; i < 8; i++) check(got[i+1] == d[i], "R3 data", got[i+1], d[i]);
    if (par) check(got[9] == expPar, "R6 odd parity", got[9], expPar);
    else check(got[9] == expPar, "R5 even parity", got[9], expPar);
    check(got[10] == 1'b1, "R3 stop", got[10], 1);
    check(busy == 1'b0 && txLine == 1'b1, "R7 done", {busy, txLine}, 2'b01);
    if (injectAt >= 0) begin
      logic [7:0] rx;
      for (int i = 0; i < 8; i++) rx[i] = got[i+1];
      check(rx == d, "R8 inflight byte", rx, d);
    end
    if (holdLow) begin
      for (int k = 0; k < 20; k++) begin
        check(busy == 1'b0, "R8 held strobe", busy, 0);
        @(negedge clk16x);
      end
      wrN = 1'b1;
      @(negedge clk16x);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk16x);
    check(txLine == 1'b1 && busy == 1'b0 && txReady == 1'b1, "R1 in reset",
          {txLine, busy, txReady}, 3'b101);
    rst = 1'b0;
    repeat (4) @(negedge clk16x);
    check(txLine == 1'b1 && busy == 1'b0 && txReady == 1'b1, "R1 after reset",
          {txLine, busy, txReady}, 3'b101);
    sendFrame(8'hA5, 1'b0, -1, 1'b0);   // even parity
    sendFrame(8'h75, 1'b1, -1, 1'b0);   // odd parity, back to back (R7)
    sendFrame(8'h00, 1'b1, -1, 1'b0);
    sendFrame(8'hFF, 1'b0, -1, 1'b0);
    sendFrame(8'h3C, 1'b0, 40, 1'b0);   // strobe inside a frame (R8)
    sendFrame(8'h81, 1'b1, 170, 1'b0);  // strobe near the stop bit (R8)
    sendFrame(8'h96, 1'b0, 100, 1'b1);  // strobe held low into idle (R8)
    sendFrame(8'h01, 1'b1, -1, 1'b0);   // R10 also exercised each frame
    repeat (5) @(negedge clk16x);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule